// File: doc/BRIEF.md
# Program Counter and Call Stack Sequencer

This block holds the instruction pointer and the stack pointer of a small 32-bit processor. For each issued instruction it works out the next instruction pointer. It also drives a word-wide stack memory port for the operations that save or restore values.

Instructions are 8 bytes long. Branch offsets count whole instructions, so an offset is scaled by 8 and added to the current pointer. Subroutine calls keep their return address on the memory stack rather than in a link register. The stack grows downward in 4-byte words. A push first moves the stack pointer down and then writes. A pop first reads and then moves the pointer up.

The read data port is combinational: the word at the requested address is expected on `mem_rdata` in the same cycle. A value popped for the register file leaves through a write-back port. A system-call request is raised for the issue cycle. Two conditions stop the sequencer and hold it halted until reset: a fatal trap reported from elsewhere in the core, and a stack access through a misaligned stack pointer.

Top module: `pc_stack_seq`

## Requirements
- R1: After reset, `ip` equals IP_RESET, `sp` equals SP_RESET and `halted` is 0.
- R2: An issued opcode outside the codes 1..7 (for example 0 or 9) advances `ip` by 8, leaves `sp` unchanged and makes no memory request.
- R3: Opcode 2 (jump) sets `ip` to ip + offset*8, with `offset` taken as signed two's complement.
- R4: Opcode 1 (branch if zero) sets `ip` to ip + offset*8 when `reg_a` is zero; otherwise `ip` advances by 8.
- R5: Opcode 3 (call) writes ip+8 to address sp-4, lowers `sp` by 4 and sets `ip` to ip + offset*8.
- R6: Opcode 4 (return) reads the word at address `sp`, loads it into `ip` and raises `sp` by 4.
- R7: Opcode 5 (push) writes `reg_a` to address sp-4 and lowers `sp` by 4. Opcode 6 (pop) reads address `sp`, presents the word on `wb_data` with `wb_valid` high, raises `sp` by 4 and advances `ip` by 8.
- R8: Opcode 7 (system call) drives `sys_req` high in its issue cycle, advances `ip` by 8 and makes no memory request.
- R9: For a stack opcode (3 to 6) with `sp[1:0]` not zero, `align_trap` goes high, no memory request is made, `ip` and `sp` hold, and `halted` becomes 1.
- R10: An issue with `fatal_trap` high makes no memory request, write-back or system call, holds `ip` and `sp`, and sets `halted`.
- R11: While `halted` is 1, issued instructions change nothing and produce no request until reset.
- R12: With `issue` low, `ip` and `sp` hold and every request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An instruction is presented this cycle |
| op | input | 4 | Opcode: 1 branch-if-zero, 2 jump, 3 call, 4 return, 5 push, 6 pop, 7 system call, others plain |
| offset | input | XLEN | Signed branch offset in instructions |
| reg_a | input | XLEN | Value of the instruction's first register operand |
| fatal_trap | input | 1 | A fatal trap was raised for this instruction |
| mem_rdata | input | XLEN | Combinational read data of the stack memory |
| ip | output | XLEN | Current instruction pointer |
| sp | output | XLEN | Current stack pointer |
| halted | output | 1 | Sequencer stopped by a trap |
| mem_req | output | 1 | Stack memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | XLEN | Byte address of the access |
| mem_wdata | output | XLEN | Write data |
| wb_valid | output | 1 | Popped word is to be written to the register file |
| wb_data | output | XLEN | Popped word |
| sys_req | output | 1 | System-call request |
| align_trap | output | 1 | Misaligned stack access trapped this cycle |

## Verification
The main instance is built with IP_RESET = 0x100 and SP_RESET = 0x40. This places the stack inside a 64-word bench memory, so nested pushes, a call with a push and pop inside it, and the matching return all land on addresses the bench can model exactly. A second instance uses SP_RESET = 0x42. Because the pointer only ever moves in steps of 4, a misaligned stack pointer can only be reached through the reset value, and that instance exercises the alignment trap. Negative jump offsets and a fatal trap followed by ignored issues are driven on the main instance.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [3:0] {
        OP_PLAIN = 4'd0,
        OP_BEZ   = 4'd1,
        OP_JMP   = 4'd2,
        OP_CALL  = 4'd3,
        OP_RET   = 4'd4,
        OP_PUSH  = 4'd5,
        OP_POP   = 4'd6,
        OP_SYS   = 4'd7
    } op_e;

    typedef struct packed {
        logic bez;
        logic jmp;
        logic call;
        logic ret;
        logic push;
        logic pop;
        logic sys;
    } dec_t;

endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [3:0] op,
    output dec_t       dec
);
    always_comb begin
        dec = '0;
        case (op)
            OP_BEZ:  dec.bez  = 1'b1;
            OP_JMP:  dec.jmp  = 1'b1;
            OP_CALL: dec.call = 1'b1;
            OP_RET:  dec.ret  = 1'b1;
            OP_PUSH: dec.push = 1'b1;
            OP_POP:  dec.pop  = 1'b1;
            OP_SYS:  dec.sys  = 1'b1;
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/seq_flow_target.sv
module seq_flow_target #(
    parameter int XLEN        = 32,
    parameter int INSTR_BYTES = 8
) (
    input  logic [XLEN-1:0] cur_ip,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] seq_ip,
    output logic [XLEN-1:0] br_ip
);
    localparam int SHIFT = $clog2(INSTR_BYTES);

    always_comb begin
        seq_ip = cur_ip + XLEN'(INSTR_BYTES);
        br_ip  = cur_ip + (offset << SHIFT);
    end
endmodule

// File: rtl/seq_stack_port.sv
module seq_stack_port #(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [XLEN-1:0] cur_sp,
    output logic [XLEN-1:0] dn_sp,
    output logic [XLEN-1:0] up_sp,
    output logic            aligned
);
    localparam int ALN = $clog2(WORD_BYTES);

    assign dn_sp = cur_sp - XLEN'(WORD_BYTES);
    assign up_sp = cur_sp + XLEN'(WORD_BYTES);

    generate
        if (ALN == 0) begin : g_byte
            assign aligned = 1'b1;
        end else begin : g_word
            assign aligned = (cur_sp[ALN-1:0] == '0);
        end
    endgenerate
endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq
    import seq_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          INSTR_BYTES = 8,
    parameter int          WORD_BYTES  = 4,
    parameter logic [31:0] IP_RESET    = 32'h0000_0100,
    parameter logic [31:0] SP_RESET    = 32'h0000_0040
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [3:0]      op,
    input  logic [XLEN-1:0] offset,
    input  logic [XLEN-1:0] reg_a,
    input  logic            fatal_trap,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] ip,
    output logic [XLEN-1:0] sp,
    output logic            halted,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            wb_valid,
    output logic [XLEN-1:0] wb_data,
    output logic            sys_req,
    output logic            align_trap
);
    typedef struct packed {
        logic [XLEN-1:0] ip;
        logic [XLEN-1:0] sp;
        logic            halted;
    } state_t;

    state_t st_q, st_d;
    dec_t   dec;
    logic [XLEN-1:0] seq_ip, br_ip, dn_sp, up_sp;
    logic            sp_aligned;
    logic            stack_op;

    seq_decode u_dec (.op(op), .dec(dec));

    seq_flow_target #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) u_tgt (
        .cur_ip(st_q.ip), .offset(offset), .seq_ip(seq_ip), .br_ip(br_ip)
    );

    seq_stack_port #(.XLEN(XLEN), .WORD_BYTES(WORD_BYTES)) u_stk (
        .cur_sp(st_q.sp), .dn_sp(dn_sp), .up_sp(up_sp), .aligned(sp_aligned)
    );

    assign stack_op = dec.call | dec.ret | dec.push | dec.pop;

    always_comb begin
        st_d       = st_q;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        wb_valid   = 1'b0;
        wb_data    = '0;
        sys_req    = 1'b0;
        align_trap = 1'b0;
        if (issue && !st_q.halted) begin
            if (fatal_trap) begin
                st_d.halted = 1'b1;
            end else if (stack_op && !sp_aligned) begin
                align_trap  = 1'b1;
                st_d.halted = 1'b1;
            end else begin
                st_d.ip = seq_ip;
                if (dec.bez && (reg_a == '0)) begin
                    st_d.ip = br_ip;
                end
                if (dec.jmp) begin
                    st_d.ip = br_ip;
                end
                if (dec.call) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = dn_sp;
                    mem_wdata = seq_ip;
                    st_d.sp   = dn_sp;
                    st_d.ip   = br_ip;
                end
                if (dec.ret) begin
                    mem_req  = 1'b1;
                    mem_addr = st_q.sp;
                    st_d.sp  = up_sp;
                    st_d.ip  = mem_rdata;
                end
                if (dec.push) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = dn_sp;
                    mem_wdata = reg_a;
                    st_d.sp   = dn_sp;
                end
                if (dec.pop) begin
                    mem_req  = 1'b1;
                    mem_addr = st_q.sp;
                    wb_valid = 1'b1;
                    wb_data  = mem_rdata;
                    st_d.sp  = up_sp;
                end
                if (dec.sys) begin
                    sys_req = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ip     <= XLEN'(IP_RESET);
            st_q.sp     <= XLEN'(SP_RESET);
            st_q.halted <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ip     = st_q.ip;
    assign sp     = st_q.sp;
    assign halted = st_q.halted;

    // R11: once stopped, the pointers stay put and the flag stays set
    a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(ip) && $stable(sp));

    // R11: no stack traffic while stopped
    a_r11_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req && !wb_valid && !sys_req);

    // R7: the stack pointer only ever moves by one word
    a_r7_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sp == $past(sp)) || (sp == $past(sp) + XLEN'(WORD_BYTES))
                 || (sp == $past(sp) - XLEN'(WORD_BYTES)));

    // R12: nothing issued, nothing changes
    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> $stable(ip) && $stable(sp));

    // R9: a misaligned access never reaches memory
    a_r9_trap_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        align_trap |-> !mem_req);

    // R2: a plain instruction moves to the next one
    a_r2_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !halted && !fatal_trap && (op == 4'd0)
        |=> ip == $past(ip) + XLEN'(INSTR_BYTES));
endmodule

// File: tb/test_pc_stack_seq.sv
module test_pc_stack_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] offset = '0;
    logic [31:0] reg_a = '0;
    logic        fatal_trap = 1'b0;
    logic [31:0] mem_rdata;
    logic [31:0] ip, sp, mem_addr, mem_wdata, wb_data;
    logic        halted, mem_req, mem_we, wb_valid, sys_req, align_trap;

    logic        o_issue = 1'b0;
    logic [3:0]  o_op = '0;
    logic [31:0] o_ip, o_sp, o_addr, o_wdata, o_wb_data;
    logic        o_halted, o_req, o_we, o_wb_valid, o_sys, o_align;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    logic [31:0] mem [64];
    logic [31:0] r_mem [64];
    assign mem_rdata = mem[mem_addr[7:2]];
    always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;

    pc_stack_seq #(.IP_RESET(32'h100), .SP_RESET(32'h40)) i_pc_stack_seq (
        .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .offset(offset),
        .reg_a(reg_a), .fatal_trap(fatal_trap), .mem_rdata(mem_rdata),
        .ip(ip), .sp(sp), .halted(halted), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wb_valid(wb_valid),
        .wb_data(wb_data), .sys_req(sys_req), .align_trap(align_trap));

    pc_stack_seq #(.IP_RESET(32'h100), .SP_RESET(32'h42)) i_pc_stack_seq_odd (
        .clk(clk), .rst_n(rst_n), .issue(o_issue), .op(o_op), .offset(32'd0),
        .reg_a(32'd5), .fatal_trap(1'b0), .mem_rdata(32'd0),
        .ip(o_ip), .sp(o_sp), .halted(o_halted), .mem_req(o_req), .mem_we(o_we),
        .mem_addr(o_addr), .mem_wdata(o_wdata), .wb_valid(o_wb_valid),
        .wb_data(o_wb_data), .sys_req(o_sys), .align_trap(o_align));

    typedef struct {
        string       tag;
        logic        req, we, wbv, sys, aln, halt;
        logic [31:0] addr, wdata, wbd, ip, sp;
    } exp_t;
    exp_t q[$];

    logic [31:0] r_ip = 32'h100;
    logic [31:0] r_sp = 32'h40;
    logic        r_halt = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic do_op(input bit iss, input logic [3:0] o, input logic [31:0] off,
                         input logic [31:0] ra, input bit trap, input string tag);
        exp_t e;
        logic [31:0] seqv, brv;
        @(negedge clk);
        issue = iss; op = o; offset = off; reg_a = ra; fatal_trap = trap;
        e.tag = tag; e.req = 0; e.we = 0; e.wbv = 0; e.sys = 0; e.aln = 0;
        e.addr = 0; e.wdata = 0; e.wbd = 0;
        seqv = r_ip + 32'd8;
        brv  = r_ip + (off << 3);
        if (iss && !r_halt) begin
            if (trap) r_halt = 1'b1;
            else if (o >= 4'd3 && o <= 4'd6 && r_sp[1:0] != 2'b00) begin
                e.aln = 1; r_halt = 1'b1;
            end else begin
                case (o)
                    4'd1: r_ip = (ra == 0) ? brv : seqv;
                    4'd2: r_ip = brv;
                    4'd3: begin
                        e.req = 1; e.we = 1; e.addr = r_sp - 4; e.wdata = seqv;
                        r_mem[e.addr[7:2]] = seqv; r_sp = r_sp - 4; r_ip = brv;
                    end
                    4'd4: begin
                        e.req = 1; e.addr = r_sp; r_ip = r_mem[r_sp[7:2]]; r_sp = r_sp + 4;
                    end
                    4'd5: begin
                        e.req = 1; e.we = 1; e.addr = r_sp - 4; e.wdata = ra;
                        r_mem[e.addr[7:2]] = ra; r_sp = r_sp - 4; r_ip = seqv;
                    end
                    4'd6: begin
                        e.req = 1; e.addr = r_sp; e.wbv = 1; e.wbd = r_mem[r_sp[7:2]];
                        r_sp = r_sp + 4; r_ip = seqv;
                    end
                    4'd7: begin e.sys = 1; r_ip = seqv; end
                    default: r_ip = seqv;
                endcase
            end
        end
        e.ip = r_ip; e.sp = r_sp; e.halt = r_halt;
        q.push_back(e);
    endtask

    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            #3;
            if (q.size() > 0) begin
                e = q[0];
                chk(mem_req == e.req, {e.tag, " mem_req"}, 32'(mem_req), 32'(e.req));
                chk(mem_we == e.we, {e.tag, " mem_we"}, 32'(mem_we), 32'(e.we));
                if (e.req) chk(mem_addr == e.addr, {e.tag, " mem_addr"}, mem_addr, e.addr);
                if (e.we) chk(mem_wdata == e.wdata, {e.tag, " mem_wdata"}, mem_wdata, e.wdata);
                chk(wb_valid == e.wbv, {e.tag, " wb_valid"}, 32'(wb_valid), 32'(e.wbv));
                if (e.wbv) chk(wb_data == e.wbd, {e.tag, " wb_data"}, wb_data, e.wbd);
                chk(sys_req == e.sys, {e.tag, " sys_req"}, 32'(sys_req), 32'(e.sys));
                chk(align_trap == e.aln, {e.tag, " align_trap"}, 32'(align_trap), 32'(e.aln));
                @(posedge clk);
                #1;
                chk(ip == e.ip, {e.tag, " ip"}, ip, e.ip);
                chk(sp == e.sp, {e.tag, " sp"}, sp, e.sp);
                chk(halted == e.halt, {e.tag, " halted"}, 32'(halted), 32'(e.halt));
                void'(q.pop_front());
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin mem[i] = '0; r_mem[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        chk(ip == 32'h100, "R1 reset ip", ip, 32'h100);
        chk(sp == 32'h40, "R1 reset sp", sp, 32'h40);
        chk(halted == 1'b0, "R1 reset halted", 32'(halted), 0);
        chk(o_sp == 32'h42, "R1 reset sp odd", o_sp, 32'h42);
        @(negedge clk);
        rst_n = 1'b1;

        do_op(0, 4'd2, 32'd5, 0, 0, "R12 idle");
        do_op(1, 4'd0, 0, 0, 0, "R2 plain op0");
        do_op(1, 4'd9, 32'd4, 0, 0, "R2 plain op9");
        do_op(1, 4'd2, 32'd3, 0, 0, "R3 jump fwd");
        do_op(1, 4'd2, -32'sd2, 0, 0, "R3 jump back");
        do_op(1, 4'd1, 32'd5, 32'd0, 0, "R4 bez taken");
        do_op(1, 4'd1, 32'd5, 32'd7, 0, "R4 bez not taken");
        do_op(1, 4'd5, 0, 32'hdead_beef, 0, "R7 push a");
        do_op(1, 4'd5, 0, 32'h0000_1234, 0, "R7 push b");
        do_op(1, 4'd6, 0, 0, 0, "R7 pop b");
        do_op(1, 4'd6, 0, 0, 0, "R7 pop a");
        do_op(1, 4'd3, 32'd10, 0, 0, "R5 call");
        do_op(1, 4'd5, 0, 32'h55, 0, "R7 push in call");
        do_op(1, 4'd6, 0, 0, 0, "R7 pop in call");
        do_op(1, 4'd4, 0, 0, 0, "R6 ret");
        do_op(1, 4'd7, 0, 0, 0, "R8 syscall");
        do_op(0, 4'd7, 0, 0, 0, "R12 idle after sys");
        do_op(1, 4'd2, 32'd8, 0, 1, "R10 fatal trap");
        do_op(1, 4'd2, 32'd8, 0, 0, "R11 jump while halted");
        do_op(1, 4'd5, 0, 32'h77, 0, "R11 push while halted");
        do_op(1, 4'd7, 0, 0, 0, "R11 sys while halted");
        wait (q.size() == 0);

        @(negedge clk);
        o_issue = 1'b1; o_op = 4'd0;
        @(posedge clk); #1;
        chk(o_ip == 32'h108, "R2 odd plain ip", o_ip, 32'h108);
        @(negedge clk);
        o_op = 4'd5;
        #3;
        chk(o_req == 1'b0, "R9 odd push no req", 32'(o_req), 0);
        chk(o_align == 1'b1, "R9 odd push trap", 32'(o_align), 1);
        @(posedge clk); #1;
        chk(o_halted == 1'b1, "R9 odd halted", 32'(o_halted), 1);
        chk(o_ip == 32'h108, "R9 odd ip held", o_ip, 32'h108);
        chk(o_sp == 32'h42, "R9 odd sp held", o_sp, 32'h42);
        @(negedge clk);
        o_issue = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule